// File: doc/BRIEF.md
# Sticky Bus Status Register with Write-One-to-Clear

This block holds the 16-bit status word of a bus configuration header. Four error and abort flags in the upper byte are sticky. Each one is set by a single-cycle event pulse from the bus logic and stays set until software writes a one to that bit. The lower bits carry fixed capability information set by parameters. This includes the two-bit DEVSEL response-speed code. Writes never change these lower bits.

Reads have no side effects. The full word is always visible on the read port as a registered view of the flags combined with the constant fields. A write clears exactly the flag bits that carry a one in the write data. The clear happens only when the byte lane holding the flags is enabled. A flag whose set event arrives in the same cycle as its clear stays set, so no event is lost.

The design has no sequencing, so it has no state machine. Each flag is a two-state sticky bit with two named transitions: SET, taken on its qualified event, and CLEAR, taken on an enabled write of one with no event in the same cycle. Every other cycle holds the bit.

Top module: `stsreg_status`

## Requirements
- R1: After reset, the four flags (bits 15:12) read as zero. Bit 11 reads as zero. Bits 10:9 read as the DEVSEL parameter, which defaults to 01 (medium). Bits 8:0 read as the capability parameter, which defaults to 9'h010. The default reset word is 0x0210.
- R2: A pulse on `perr_detect_i` sets bit 15 on the next clock edge. No enable qualifies this bit.
- R3: A pulse on `serr_assert_i` sets bit 14 on the next clock edge.
- R4: A pulse on `mabort_i` sets bit 13 on the next clock edge, unless `mabort_special_i` is high in the same cycle. When it is high, bit 13 is unchanged.
- R5: A pulse on `tabort_i` sets bit 12 on the next clock edge.
- R6: A write with `wr_be_i[1]` high clears each flag bit 15:12 whose write-data bit is one. Flags written as zero keep their value. For example, writing 0x8000 clears only bit 15.
- R7: A write with `wr_be_i[1]` low changes no flag, whatever the write data.
- R8: If a set event and a clear hit the same flag in the same cycle, the flag is set afterwards.
- R9: Bits 11:0 never change, whatever is written. The DEVSEL code in bits 10:9 uses 00 for fast, 01 for medium, 10 for slow and 11 for reserved.
- R10: With no event and no enabled write, every flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| perr_detect_i | input | 1 | Data parity error detected (pulse) |
| serr_assert_i | input | 1 | Device drove its system-error output (pulse) |
| mabort_i | input | 1 | Own transaction ended in master abort (pulse) |
| mabort_special_i | input | 1 | The aborted transaction was a special cycle |
| tabort_i | input | 1 | Own transaction terminated by target abort (pulse) |
| wr_en_i | input | 1 | Register write strobe |
| wr_be_i | input | 2 | Byte enables, bit 1 covers bits 15:8 |
| wr_data_i | input | 16 | Write data, ones select flags to clear |
| rd_data_o | output | 16 | Current register word |

## Verification
The bench targets three cases directly: a clear that collides with the same flag's set event, a write whose flag byte lane is disabled, and a master abort flagged as a special cycle. A design that gives clear priority would drop the colliding event. A design that ignores the byte enables would wipe flags on a low-byte write. A design that skips the qualifier would report aborts of broadcast cycles. Writes of all ones check that the constant fields, including the DEVSEL code and the reserved zero, cannot be altered. A long random mix of events and partial writes is compared cycle by cycle against a bench model of the sticky rules.

// File: rtl/stsreg_pkg.sv
package stsreg_pkg;
    typedef enum logic [1:0] {
        DSEL_FAST   = 2'b00,
        DSEL_MEDIUM = 2'b01,
        DSEL_SLOW   = 2'b10,
        DSEL_RSVD   = 2'b11
    } devsel_speed_e;

    // flag vector index order (LSB first): target abort, master abort,
    // system error, parity error
    localparam int unsigned FLG_TABORT = 0;
    localparam int unsigned FLG_MABORT = 1;
    localparam int unsigned FLG_SERR   = 2;
    localparam int unsigned FLG_PERR   = 3;
    localparam int unsigned FLG_COUNT  = 4;
endpackage

// File: rtl/stsreg_event_qual.sv
module stsreg_event_qual
    import stsreg_pkg::*;
(
    input  logic                 perr_detect_i,
    input  logic                 serr_assert_i,
    input  logic                 mabort_i,
    input  logic                 mabort_special_i,
    input  logic                 tabort_i,
    output logic [FLG_COUNT-1:0] set_vec_o
);
    always_comb begin
        set_vec_o             = '0;
        set_vec_o[FLG_PERR]   = perr_detect_i;
        set_vec_o[FLG_SERR]   = serr_assert_i;
        set_vec_o[FLG_MABORT] = mabort_i & ~mabort_special_i;
        set_vec_o[FLG_TABORT] = tabort_i;
    end
endmodule

// File: rtl/stsreg_clear_decode.sv
module stsreg_clear_decode #(
    parameter int unsigned WORD_W   = 16,
    parameter int unsigned FLAG_LSB = 12,
    parameter int unsigned NFLAGS   = 4,
    localparam int unsigned BE_W    = WORD_W / 8,
    localparam int unsigned LANE    = FLAG_LSB / 8
) (
    input  logic              wr_en_i,
    input  logic [BE_W-1:0]   wr_be_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [NFLAGS-1:0] clr_vec_o
);
    always_comb begin
        clr_vec_o = '0;
        if (wr_en_i && wr_be_i[LANE]) begin
            clr_vec_o = wr_data_i[FLAG_LSB +: NFLAGS];
        end
    end
endmodule

// File: rtl/stsreg_sticky_bit.sv
module stsreg_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= 1'b0;
        end else if (set_i) begin
            q_o <= 1'b1;
        end else if (clr_i) begin
            q_o <= 1'b0;
        end
    end
endmodule

// File: rtl/stsreg_status.sv
module stsreg_status
    import stsreg_pkg::*;
#(
    parameter devsel_speed_e DEVSEL_SPEED = DSEL_MEDIUM,
    parameter logic [8:0]    LOW_CAPS     = 9'h010,
    localparam int unsigned  WORD_W       = 16,
    localparam int unsigned  BE_W         = WORD_W / 8,
    localparam int unsigned  FLAG_LSB     = WORD_W - FLG_COUNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              perr_detect_i,
    input  logic              serr_assert_i,
    input  logic              mabort_i,
    input  logic              mabort_special_i,
    input  logic              tabort_i,
    input  logic              wr_en_i,
    input  logic [BE_W-1:0]   wr_be_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [WORD_W-1:0] rd_data_o
);
    logic [FLG_COUNT-1:0] set_vec;
    logic [FLG_COUNT-1:0] clr_vec;
    logic [FLG_COUNT-1:0] flags_q;
    logic                 unused_ok;

    assign unused_ok = ^{wr_data_i[FLAG_LSB-1:0], wr_be_i[0]};

    stsreg_event_qual u_qual (
        .perr_detect_i    (perr_detect_i),
        .serr_assert_i    (serr_assert_i),
        .mabort_i         (mabort_i),
        .mabort_special_i (mabort_special_i),
        .tabort_i         (tabort_i),
        .set_vec_o        (set_vec)
    );

    stsreg_clear_decode #(
        .WORD_W   (WORD_W),
        .FLAG_LSB (FLAG_LSB),
        .NFLAGS   (FLG_COUNT)
    ) u_clr (
        .wr_en_i   (wr_en_i),
        .wr_be_i   (wr_be_i),
        .wr_data_i (wr_data_i),
        .clr_vec_o (clr_vec)
    );

    for (genvar g = 0; g < FLG_COUNT; g++) begin : g_flag
        stsreg_sticky_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[g]),
            .clr_i (clr_vec[g]),
            .q_o   (flags_q[g])
        );
    end

    always_comb begin
        rd_data_o = {flags_q, 1'b0, DEVSEL_SPEED, LOW_CAPS};
    end
endmodule

// File: rtl/stsreg_status_chk.sv
module stsreg_status_chk
    import stsreg_pkg::*;
#(
    parameter devsel_speed_e DEVSEL_SPEED = DSEL_MEDIUM,
    parameter logic [8:0]    LOW_CAPS     = 9'h010
) (
    input logic        clk,
    input logic        rst_n,
    input logic        perr_detect_i,
    input logic        serr_assert_i,
    input logic        mabort_i,
    input logic        mabort_special_i,
    input logic        tabort_i,
    input logic        wr_en_i,
    input logic [1:0]  wr_be_i,
    input logic [15:0] wr_data_i,
    input logic [15:0] rd_data_o
);
    logic any_ev;
    logic hi_wr;
    logic unused_ok;
    assign any_ev    = perr_detect_i | serr_assert_i | mabort_i | tabort_i;
    assign hi_wr     = wr_en_i & wr_be_i[1];
    assign unused_ok = ^{wr_data_i[11:0], wr_be_i[0]};

    AST_PERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        perr_detect_i |=> rd_data_o[15]); // R2
    AST_SERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        serr_assert_i |=> rd_data_o[14]); // R3
    AST_MABORT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (mabort_i && !mabort_special_i) |=> rd_data_o[13]); // R4
    AST_SPECIAL_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (mabort_special_i && !rd_data_o[13]) |=> !rd_data_o[13]); // R4
    AST_TABORT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        tabort_i |=> rd_data_o[12]); // R5
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr && wr_data_i[15] && !perr_detect_i) |=> !rd_data_o[15]); // R6
    AST_LANE_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_be_i[1] && !any_ev) |=> $stable(rd_data_o[15:12])); // R7
    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_wr && wr_data_i[12] && tabort_i) |=> rd_data_o[12]); // R8
    AST_FIXED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[11:0] == {1'b0, DEVSEL_SPEED, LOW_CAPS}); // R9
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_ev && !hi_wr) |=> $stable(rd_data_o[15:12])); // R10
endmodule

bind stsreg_status stsreg_status_chk #(
    .DEVSEL_SPEED (DEVSEL_SPEED),
    .LOW_CAPS     (LOW_CAPS)
) u_chk (.*);

// File: tb/stsreg_status_bench.sv
module stsreg_status_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [11:0] LOW_EXP = {1'b0, 2'b01, 9'h010};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        perr = 1'b0, serr = 1'b0, ma = 1'b0, sp = 1'b0, ta = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  be = 2'b00;
    logic [15:0] wd = 16'h0000;
    logic [15:0] rd;
    logic [3:0]  model = 4'h0;
    int          total = 0;
    int          bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stsreg_status u_stsreg_status (
        .clk(clk), .rst_n(rst_n),
        .perr_detect_i(perr), .serr_assert_i(serr),
        .mabort_i(ma), .mabort_special_i(sp), .tabort_i(ta),
        .wr_en_i(we), .wr_be_i(be), .wr_data_i(wd),
        .rd_data_o(rd)
    );

    function automatic logic [3:0] next_flags(
        input logic [3:0] cur, input logic p, input logic s,
        input logic m, input logic spc, input logic t,
        input logic w, input logic [1:0] b, input logic [15:0] d);
        logic [3:0] setv;
        logic [3:0] clrv;
        setv = {p, s, m & ~spc, t};
        clrv = (w && b[1]) ? d[15:12] : 4'h0;
        return setv | (cur & ~clrv);
    endfunction

    task automatic check(input string req, input logic [15:0] exp);
        total++;
        if (rd !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, rd, exp);
        end
    endtask

    // drive at negedge, edge updates, compare at following negedge
    task automatic cycle(input logic p, input logic s, input logic m,
                         input logic spc, input logic t, input logic w,
                         input logic [1:0] b, input logic [15:0] d,
                         input string req);
        perr = p; serr = s; ma = m; sp = spc; ta = t;
        we = w; be = b; wd = d;
        model = next_flags(model, p, s, m, spc, t, w, b, d);
        @(negedge clk);
        check(req, {model, LOW_EXP});
        perr = 0; serr = 0; ma = 0; sp = 0; ta = 0; we = 0; be = 0; wd = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1", 16'h0210);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 16'h0210);

        cycle(1, 0, 0, 0, 0, 0, 2'b00, 16'h0, "R2");
        cycle(0, 1, 0, 0, 0, 0, 2'b00, 16'h0, "R3");
        cycle(0, 0, 1, 1, 0, 0, 2'b00, 16'h0, "R4");
        cycle(0, 0, 1, 0, 0, 0, 2'b00, 16'h0, "R4");
        cycle(0, 0, 0, 0, 1, 0, 2'b00, 16'h0, "R5");
        cycle(0, 0, 0, 0, 0, 0, 2'b00, 16'h0, "R10");
        cycle(0, 0, 0, 0, 0, 1, 2'b01, 16'hF000, "R7");
        cycle(0, 0, 0, 0, 0, 1, 2'b10, 16'h8000, "R6");
        cycle(0, 0, 0, 0, 0, 1, 2'b11, 16'h0FFF, "R9");
        cycle(0, 0, 0, 0, 1, 1, 2'b10, 16'h1000, "R8");
        cycle(0, 1, 0, 0, 0, 1, 2'b10, 16'h7000, "R8");
        cycle(0, 0, 0, 0, 0, 1, 2'b11, 16'hFFFF, "R6");
        cycle(0, 0, 1, 1, 0, 0, 2'b00, 16'h0, "R4");

        for (int i = 0; i < 3000; i++) begin
            logic [15:0] d;
            d = 16'($urandom);
            cycle(($urandom % 8) == 0, ($urandom % 8) == 0,
                  ($urandom % 6) == 0, ($urandom % 2) == 0,
                  ($urandom % 8) == 0, ($urandom % 4) == 0,
                  2'($urandom), d, "R10");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule